// File: doc/BRIEF.md
# Transmit Bit Error Injector

This block sits in the serial transmit path of a bit-error-rate tester. Each clock it takes one data bit with a valid strobe, and it passes the bit on one cycle later. On selected bits it inverts the data, so that the receiving side sees a known amount of errors. Only cycles with the valid strobe high are injection opportunities. An inverted bit is always the data bit of such a cycle.

Two injection sources can be active at the same time. The periodic source inverts one valid bit in every 10^n, where n is a 3-bit rate code. The one-shot source inverts exactly one bit for each rising edge of a request flag, and a separate enable gates it. Both are set through an 8-bit control byte that is loaded by a one-cycle write strobe. A rate change made while periodic injection is running is held back until the next periodic error has been inserted. Several request edges that arrive before an opportunity are merged into a single error.

Top module: `bit_err_inject`

## Requirements
- R1: `tx_vld_o` equals `tx_vld_i` delayed by one clock. `tx_bit_o` equals `tx_bit_i` delayed by one clock, except on inverted bits. A cycle with `tx_vld_i` low is never inverted.
- R2: The control byte maps as follows: bits 5:3 are the rate code n, bit 2 is the one-shot enable, and bit 1 is the one-shot request. Bits 7:6 and bit 0 have no effect. A write acts from the clock after the `cfg_wr` cycle.
- R3: A write with n != 0 while the periodic source is idle starts it. The (k*10^n)-th valid bit counted after the write is inverted, for k = 1, 2, 3, and so on.
- R4: While the periodic source is idle and only rate code 0 has been written, it inverts no bits.
- R5: A write made while the periodic source is running does not change the spacing until the next periodic error. From that error on, the new code applies. A code of 0 stops the source after that error.
- R6: A write with bit 2 = 1 and bit 1 = 1, when the previously written bit 1 was 0, inverts the next valid bit once. A write that keeps bit 1 at 1 requests nothing.
- R7: A write with bit 2 = 0 ignores the request bit and cancels any one-shot request that is still pending.
- R8: Several request edges before the next valid bit produce exactly one inverted bit.
- R9: When a periodic error and a one-shot error fall on the same valid bit, that bit is inverted once. Both sources count as served.
- R10: After reset, both outputs are 0 and neither source is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | One-cycle control byte write strobe |
| cfg_byte | input | 8 | Control byte written on `cfg_wr` |
| tx_bit_i | input | 1 | Transmit data bit in |
| tx_vld_i | input | 1 | Data bit valid in |
| tx_bit_o | output | 1 | Transmit data bit out, possibly inverted |
| tx_vld_o | output | 1 | Data bit valid out |

## Verification
The hardest situation to reach from the ports is a coincidence: a one-shot request that lands on exactly the same valid bit as a periodic error. The stimulus gets there by counting valid bits, with idle gaps, from a rate-1 start. It then places the enable and request writes in cycles with valid low, just before the tenth valid bit. The deferred rate change is reached in a similar way. A new code is written a known number of bits into a period, and the bench computes the expected inversion positions under both the old and the new spacing.

// File: rtl/bei_pkg.sv
package bei_pkg;

  localparam int unsigned RATE_MAX = 7;

  // control byte, MSB first
  typedef struct packed {
    logic [1:0] rsvd_hi;
    logic [2:0] rate;
    logic       sgl_en;
    logic       sgl_req;
    logic       rsvd_lo;
  } ctrl_t;

  function automatic int unsigned pow10(input int unsigned n);
    int unsigned p;
    p = 1;
    for (int i = 0; i < int'(RATE_MAX); i++) begin
      if (i < int'(n)) p = p * 10;
    end
    return p;
  endfunction

endpackage

// File: rtl/bei_cfg_reg.sv
module bei_cfg_reg
  import bei_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_byte,
  input  logic       tx_vld,
  output logic       single_pend,
  output logic       single_fire
);

  ctrl_t cfg;
  logic  req_q, req_d;
  logic  pend_q, pend_d;
  logic  rise;
  logic  unused_rsvd;

  assign cfg         = ctrl_t'(cfg_byte);
  assign unused_rsvd = ^{cfg.rsvd_hi, cfg.rsvd_lo, cfg.rate};

  assign rise        = cfg_wr && cfg.sgl_en && cfg.sgl_req && !req_q;
  assign single_fire = tx_vld && pend_q;
  assign single_pend = pend_q;

  always_comb begin
    req_d  = req_q;
    pend_d = pend_q;
    if (single_fire) pend_d = 1'b0;
    if (cfg_wr) begin
      req_d = cfg.sgl_req;
      if (!cfg.sgl_en) pend_d = 1'b0;
      else if (rise)   pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/bei_rate_gen.sv
module bei_rate_gen
  import bei_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RATE_W-1:0] new_rate,
  input  logic              tx_vld,
  output logic              rate_fire,
  output logic [RATE_W-1:0] act_rate,
  output logic [CNT_W-1:0]  rate_cnt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [RATE_W-1:0] act_q, act_d, pnd_q, pnd_d;
  logic              pv_q, pv_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  period;
  logic              running;

  assign period    = CNT_W'(pow10(32'(act_q)));
  assign running   = (act_q != '0);
  assign rate_fire = tx_vld && running && (cnt_q == period - ONE);
  assign act_rate  = act_q;
  assign rate_cnt  = cnt_q;

  always_comb begin
    act_d = act_q;
    pnd_d = pnd_q;
    pv_d  = pv_q;
    cnt_d = cnt_q;
    if (rate_fire) begin
      cnt_d = '0;
      if (pv_q) begin
        act_d = pnd_q;
        pv_d  = 1'b0;
      end
    end else if (tx_vld && running) begin
      cnt_d = cnt_q + ONE;
    end
    if (load) begin
      if (!running) begin
        act_d = new_rate;
        cnt_d = '0;
        pv_d  = 1'b0;
      end else begin
        pnd_d = new_rate;
        pv_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      pnd_q <= '0;
      pv_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      pnd_q <= pnd_d;
      pv_q  <= pv_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/bei_flip_stage.sv
module bei_flip_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_bit,
  input  logic tx_vld,
  input  logic flip,
  output logic out_bit,
  output logic out_vld
);

  logic bit_d;

  assign bit_d = tx_bit ^ (flip && tx_vld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_bit <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      out_bit <= bit_d;
      out_vld <= tx_vld;
    end
  end

endmodule

// File: rtl/bit_err_inject.sv
module bit_err_inject
  import bei_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int RATE_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_byte,
  input  logic       tx_bit_i,
  input  logic       tx_vld_i,
  output logic       tx_bit_o,
  output logic       tx_vld_o
);

  logic              rst_meta, rst_q;
  logic              single_pend, single_fire, rate_fire;
  logic [RATE_W-1:0] act_rate;
  logic [CNT_W-1:0]  rate_cnt;
  ctrl_t             cfg;

  assign cfg = ctrl_t'(cfg_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  bei_cfg_reg cfg_i (
    .clk         (clk),
    .rst_n       (rst_q),
    .cfg_wr      (cfg_wr),
    .cfg_byte    (cfg_byte),
    .tx_vld      (tx_vld_i),
    .single_pend (single_pend),
    .single_fire (single_fire)
  );

  bei_rate_gen #(.CNT_W(CNT_W), .RATE_W(RATE_W)) rate_i (
    .clk       (clk),
    .rst_n     (rst_q),
    .load      (cfg_wr),
    .new_rate  (RATE_W'(cfg.rate)),
    .tx_vld    (tx_vld_i),
    .rate_fire (rate_fire),
    .act_rate  (act_rate),
    .rate_cnt  (rate_cnt)
  );

  bei_flip_stage flip_i (
    .clk     (clk),
    .rst_n   (rst_q),
    .tx_bit  (tx_bit_i),
    .tx_vld  (tx_vld_i),
    .flip    (rate_fire | single_fire),
    .out_bit (tx_bit_o),
    .out_vld (tx_vld_o)
  );

endmodule

// File: rtl/bei_checker.sv
module bei_checker
  import bei_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int RATE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [7:0]        cfg_byte,
  input logic              tx_bit_i,
  input logic              tx_vld_i,
  input logic              tx_bit_o,
  input logic              tx_vld_o,
  input logic              rate_fire,
  input logic              single_fire,
  input logic              single_pend,
  input logic [RATE_W-1:0] act_rate,
  input logic [CNT_W-1:0]  rate_cnt
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_vld_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> tx_vld_o == $past(tx_vld_i));

  assert_no_idle_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(tx_vld_i)) |-> tx_bit_o == $past(tx_bit_i));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_rate != '0) |-> rate_cnt < CNT_W'(pow10(32'(act_rate))));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_rate == '0) |-> !rate_fire);

  assert_deferred_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_rate != '0 && !rate_fire) |=> act_rate == $past(act_rate));

  assert_single_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (single_fire && !cfg_wr) |=> !single_pend);

  assert_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_byte[2]) |=> !single_pend);

  assert_both_served_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_fire && single_fire && !cfg_wr) |=> (!single_pend && rate_cnt == '0));

endmodule

bind bit_err_inject bei_checker #(.CNT_W(CNT_W), .RATE_W(RATE_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_q),
  .cfg_wr      (cfg_wr),
  .cfg_byte    (cfg_byte),
  .tx_bit_i    (tx_bit_i),
  .tx_vld_i    (tx_vld_i),
  .tx_bit_o    (tx_bit_o),
  .tx_vld_o    (tx_vld_o),
  .rate_fire   (rate_fire),
  .single_fire (single_fire),
  .single_pend (single_pend),
  .act_rate    (act_rate),
  .rate_cnt    (rate_cnt)
);

// File: tb/bit_err_inject_tb_top.sv
module bit_err_inject_tb_top;

  logic       clk;
  logic       rst_n;
  logic       cfg_wr;
  logic [7:0] cfg_byte;
  logic       tx_bit_i, tx_vld_i;
  logic       tx_bit_o, tx_vld_o;

  int compared;
  int mismatched;
  logic [15:0] lfsr;
  int   cyc;
  int   vidx;
  int   nflips;
  int   flip_pos [0:31];
  logic have_prev, prev_bit, prev_vld;
  int   prev_idx;

  bit_err_inject dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_byte (cfg_byte),
    .tx_bit_i (tx_bit_i),
    .tx_vld_i (tx_vld_i),
    .tx_bit_o (tx_bit_o),
    .tx_vld_o (tx_vld_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // one cycle: check the previous cycle's result, then drive new inputs
  task automatic step(input logic v, input logic we, input logic [7:0] wd);
    @(negedge clk);
    if (have_prev) begin
      chk(tx_vld_o == prev_vld, "R1 valid delay", int'(tx_vld_o), int'(prev_vld));
      if (!prev_vld)
        chk(tx_bit_o == prev_bit, "R1 idle bit untouched", int'(tx_bit_o), int'(prev_bit));
      else if (tx_bit_o != prev_bit) begin
        if (nflips < 32) flip_pos[nflips] = prev_idx;
        nflips++;
      end
    end
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_bit_i = lfsr[0];
    tx_vld_i = v;
    cfg_wr   = we;
    cfg_byte = wd;
    if (v) vidx++;
    prev_idx  = vidx;
    prev_bit  = lfsr[0];
    prev_vld  = v;
    have_prev = 1'b1;
  endtask

  task automatic wr(input logic [7:0] wd);
    step(1'b0, 1'b1, wd);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 8'h00);
  endtask

  // run until n more valid bits have been sent, with periodic gaps
  task automatic run(input int n);
    int target;
    target = vidx + n;
    while (vidx < target) begin
      cyc++;
      step((cyc % 7) != 3, 1'b0, 8'h00);
    end
    idle();
    idle();
  endtask

  task automatic clear_log();
    vidx   = 0;
    nflips = 0;
  endtask

  task automatic expect_flips(input string tag, input int n,
                              input int p0, input int p1, input int p2,
                              input int p3, input int p4);
    int exp_p [0:4];
    exp_p[0] = p0; exp_p[1] = p1; exp_p[2] = p2; exp_p[3] = p3; exp_p[4] = p4;
    chk(nflips == n, {tag, " flip count"}, nflips, n);
    for (int k = 0; k < 5; k++) begin
      if (k < n && k < nflips)
        chk(flip_pos[k] == exp_p[k], {tag, " flip position"}, flip_pos[k], exp_p[k]);
    end
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    cfg_wr    = 1'b0;
    cfg_byte  = 8'h00;
    tx_vld_i  = 1'b0;
    tx_bit_i  = 1'b0;
    have_prev = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_vld_o == 1'b0, "R10 reset valid", int'(tx_vld_o), 0);
    chk(tx_bit_o == 1'b0, "R10 reset bit", int'(tx_bit_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    clear_log();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    compared   = 0;
    mismatched = 0;
    lfsr       = 16'hACE1;
    cyc        = 0;
    do_reset();

    // R10: nothing active after reset
    run(50);
    expect_flips("R10 idle after reset", 0, 0, 0, 0, 0, 0);

    // R3: sweep rate codes 1..3 from idle
    for (int n = 1; n <= 3; n++) begin
      int p;
      p = 1;
      for (int i = 0; i < n; i++) p = p * 10;
      do_reset();
      wr(8'(n << 3));
      clear_log();
      run(3 * p + 5);
      expect_flips("R3 rate sweep", 3, p, 2 * p, 3 * p, 0, 0);
    end

    // R2: reserved bits and request bit with enable low have no effect
    do_reset();
    wr(8'hC8 | 8'h03);
    clear_log();
    run(25);
    expect_flips("R2 reserved bits ignored", 2, 10, 20, 0, 0, 0);

    // R4: rate code 0 from idle
    do_reset();
    wr(8'h00);
    clear_log();
    run(200);
    expect_flips("R4 rate zero idle", 0, 0, 0, 0, 0, 0);

    // R5: deferred change, then deferred stop
    do_reset();
    wr(8'h08);
    clear_log();
    run(15);
    wr(8'h10);
    run(215);
    wr(8'h00);
    run(370);
    expect_flips("R5 deferred rate change", 5, 10, 20, 120, 220, 320);

    // R6: rising request injects once on the first valid bit
    do_reset();
    wr(8'h04);
    wr(8'h06);
    clear_log();
    idle();
    idle();
    run(20);
    expect_flips("R6 single shot", 1, 1, 0, 0, 0, 0);
    wr(8'h06);
    clear_log();
    run(20);
    expect_flips("R6 held request no edge", 0, 0, 0, 0, 0, 0);
    wr(8'h04);
    wr(8'h06);
    clear_log();
    run(20);
    expect_flips("R6 second edge", 1, 1, 0, 0, 0, 0);

    // R7: enable low ignores request and cancels a pending one
    do_reset();
    wr(8'h00);
    wr(8'h02);
    clear_log();
    run(20);
    expect_flips("R7 request with enable low", 0, 0, 0, 0, 0, 0);
    wr(8'h04);
    wr(8'h06);
    wr(8'h00);
    clear_log();
    run(20);
    expect_flips("R7 pending cancelled", 0, 0, 0, 0, 0, 0);

    // R8: several edges before an opportunity
    do_reset();
    wr(8'h04); wr(8'h06);
    wr(8'h04); wr(8'h06);
    wr(8'h04); wr(8'h06);
    clear_log();
    run(20);
    expect_flips("R8 merged edges", 1, 1, 0, 0, 0, 0);

    // R9: one-shot lands on the 10th bit of a rate-1 period
    do_reset();
    wr(8'h08);
    clear_log();
    run(9);
    wr(8'h0C);
    wr(8'h0E);
    run(26);
    expect_flips("R9 coincident errors", 3, 10, 20, 30, 0, 0);

    summary();
    $finish;
  end

endmodule